// File: doc/BRIEF.md
# Vectored Interrupt Dispatcher with Legacy Line Translation

The block sits between the interrupt sources of a system and the processor's trap logic. It watches 64 level-sensitive vector lines and 16 legacy ISA interrupt lines. A fixed built-in table moves five of the legacy lines onto vector numbers. The remaining legacy lines are dropped without effect. The translated legacy lines are ORed with the vector lines. A rising edge on any resulting line is a new request.

Only one vector interrupt is held at a time. When the block is idle and a request rises, it captures the vector number into a set of three 64-bit data words and sets a busy flag. It also raises the processor request and presents the vector trap type on a trap index output. The interrupt is retired in one of two ways: the captured line drops, or the processor pulses the acknowledge input. Requests that rise while the block is busy are not queued.

Top module: `ivec_dispatch`

## Requirements
- R1: After reset, busy, the processor request, the trap index and all three data words are zero.
- R2: When the block is idle, a 0-to-1 transition on a vector line sets busy and the processor request on the next clock edge.
- R3: On acceptance, data word 0 becomes 0x7C0 | n, where n is the vector number in bits 5:0 and the value 0x1F sits in bits 10:6. Data words 1 and 2 become zero.
- R4: While the request is asserted the trap index reads 0x60, and it reads 0 while idle.
- R5: A line that rises while busy is ignored: the data words and busy stay unchanged.
- R6: When the captured line returns to 0 while busy, busy and the request clear on the next edge. A different line dropping has no effect.
- R7: A high acknowledge while busy clears busy and the request on the next edge.
- R8: When several lines rise in the same idle cycle, the lowest-numbered one is captured.
- R9: Legacy lines map onto vector numbers as follows: 1 to 0x29, 4 to 0x2B, 6 to 0x27, 7 to 0x22, 12 to 0x2A.
- R10: Legacy lines 0, 2, 3, 5, 8 to 11 and 13 to 15 never cause a capture.
- R11: A line that is already high when the block becomes idle is not captured until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_in | input | 64 | Level-sensitive vector interrupt lines |
| legacy_in | input | 16 | Legacy ISA interrupt lines |
| ack | input | 1 | Retire the held interrupt |
| busy | output | 1 | An interrupt is held |
| data0 | output | 64 | Marker field and vector number |
| data1 | output | 64 | Cleared on capture |
| data2 | output | 64 | Cleared on capture |
| cpu_req | output | 1 | Interrupt request to the processor |
| trap_idx | output | 9 | Trap type presented with the request |

## Verification
Single vector rises are applied at the bottom, middle and top of the vector range. These show that data word 0 carries the vector number and the 0x1F marker. Simultaneous rises, and rises during a busy window, separate lowest-first priority from last-seen or queued behaviour. Each mapped legacy line is raised alone, and then all unmapped legacy lines are raised together. This exposes a wrong table entry and any leak from an unmapped line. Dropping a line other than the captured one, acknowledging while lines stay high, and holding a line across the return to idle together separate line-tracking retirement from edge-based acceptance.

// File: rtl/ivec_dispatch.sv
`timescale 1ns/1ps
module ivec_dispatch #(
  parameter int NVEC      = 64,
  parameter int NLEG      = 16,
  parameter int DW        = 64,
  parameter int TW        = 9,
  parameter int TRAP_TYPE = 'h60,
  parameter int MARK      = 'h1f
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] vec_in,
  input  logic [NLEG-1:0] legacy_in,
  input  logic            ack,
  output logic            busy,
  output logic [DW-1:0]   data0,
  output logic [DW-1:0]   data1,
  output logic [DW-1:0]   data2,
  output logic            cpu_req,
  output logic [TW-1:0]   trap_idx
);
  localparam int IW = $clog2(NVEC);

  function automatic logic [NVEC-1:0] leg_map(input logic [NLEG-1:0] l);
    logic [NVEC-1:0] m;
    m = '0;
    m['h29] = l[1];
    m['h2b] = l[4];
    m['h27] = l[6];
    m['h22] = l[7];
    m['h2a] = l[12];
    return m;
  endfunction

  logic [NVEC-1:0] lines, lines_q, rise;
  logic [IW-1:0]   pick, held;

  assign lines = vec_in | leg_map(legacy_in);
  assign rise  = lines & ~lines_q;

  always_comb begin
    pick = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (rise[i]) pick = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q  <= '0;
      busy     <= 1'b0;
      cpu_req  <= 1'b0;
      trap_idx <= '0;
      held     <= '0;
      data0    <= '0;
      data1    <= '0;
      data2    <= '0;
    end else begin
      lines_q <= lines;
      if (busy) begin
        if (ack || !lines[held]) begin
          busy     <= 1'b0;
          cpu_req  <= 1'b0;
          trap_idx <= '0;
        end
      end else if (|rise) begin
        busy     <= 1'b1;
        cpu_req  <= 1'b1;
        trap_idx <= TW'(TRAP_TYPE);
        held     <= pick;
        data0    <= (DW'(MARK) << IW) | DW'(pick);
        data1    <= '0;
        data2    <= '0;
      end
    end
  end

  AST_REQ_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> trap_idx == TW'(TRAP_TYPE)); // R4
  AST_CAPTURE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> data0[IW+4:IW] == 5'(MARK) && data1 == '0 && data2 == '0); // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack && lines[held] |=> $stable(data0) && busy); // R5
  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ack |=> !busy && !cpu_req); // R7
  AST_REQ_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy == cpu_req); // R2
endmodule

// File: tb/ivec_dispatch_tb_top.sv
`timescale 1ns/1ps
module ivec_dispatch_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] vec_in = '0;
  logic [15:0] legacy_in = '0;
  logic        ack = 0;
  logic        busy, cpu_req;
  logic [63:0] data0, data1, data2;
  logic [8:0]  trap_idx;

  always #2 clk = ~clk;

  ivec_dispatch dut_i (.clk(clk), .rst_n(rst_n), .vec_in(vec_in), .legacy_in(legacy_in),
    .ack(ack), .busy(busy), .data0(data0), .data1(data1), .data2(data2),
    .cpu_req(cpu_req), .trap_idx(trap_idx));

  typedef struct { logic b; logic [63:0] d0; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0, reported = 0;

  task automatic step(input logic [63:0] v, input logic [15:0] l, input logic a,
                      input logic eb, input logic [63:0] ed0, input string tag);
    exp_t e;
    @(negedge clk);
    vec_in = v; legacy_in = l; ack = a;
    e.b = eb; e.d0 = ed0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin : monitor
    exp_t e;
    logic [8:0] et;
    forever begin
      @(posedge clk); #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        et = e.b ? 9'h060 : 9'h000;
        checks++;
        if (busy !== e.b || cpu_req !== e.b || trap_idx !== et || data0 !== e.d0 ||
            data1 !== 64'h0 || data2 !== 64'h0) begin
          fails++;
          $display("FAIL %s: busy=%0b req=%0b trap=%h d0=%h d1=%h d2=%h expected busy=%0b req=%0b trap=%h d0=%h d1=0 d2=0",
                   e.tag, busy, cpu_req, trap_idx, data0, data1, data2, e.b, e.b, et, e.d0);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 64'h0, "R1 reset state");
    step(64'h1 << 5, 0, 0, 1, 64'h7c5, "R2 R3 R4 accept line 5");
    step((64'h1 << 5) | (64'h1 << 9), 0, 0, 1, 64'h7c5, "R5 rise while busy ignored");
    step(64'h1 << 9, 0, 0, 0, 64'h7c5, "R6 captured line lowered");
    step(64'h1 << 9, 0, 0, 0, 64'h7c5, "R11 held line not captured");
    step(0, 0, 0, 0, 64'h7c5, "R11 idle after drop");
    step((64'h1 << 40) | (64'h1 << 12) | (64'h1 << 63), 0, 0, 1, 64'h7cc, "R8 lowest line wins");
    step((64'h1 << 40) | (64'h1 << 12), 0, 0, 1, 64'h7cc, "R6 other line dropped");
    step((64'h1 << 40) | (64'h1 << 12), 0, 1, 0, 64'h7cc, "R7 acknowledge retires");
    step(0, 0, 0, 0, 64'h7cc, "R7 idle after ack");
    step(0, 16'h0010, 0, 1, 64'h7eb, "R9 legacy 4");
    step(0, 0, 0, 0, 64'h7eb, "R6 legacy drop");
    step(0, 16'h1000, 0, 1, 64'h7ea, "R9 legacy 12");
    step(0, 0, 0, 0, 64'h7ea, "R6 legacy drop");
    step(0, 16'h0002, 0, 1, 64'h7e9, "R9 legacy 1");
    step(0, 0, 0, 0, 64'h7e9, "R6 legacy drop");
    step(0, 16'h0040, 0, 1, 64'h7e7, "R9 legacy 6");
    step(0, 0, 0, 0, 64'h7e7, "R6 legacy drop");
    step(0, 16'h0080, 0, 1, 64'h7e2, "R9 legacy 7");
    step(0, 0, 0, 0, 64'h7e2, "R6 legacy drop");
    step(0, 16'hef2d, 0, 0, 64'h7e2, "R10 unmapped legacy lines");
    step(0, 16'hef2d, 0, 0, 64'h7e2, "R10 unmapped legacy held");
    step(64'h1, 16'hef2d, 0, 1, 64'h7c0, "R2 R3 line 0");
    step(0, 0, 0, 0, 64'h7c0, "R6 line 0 dropped");
    step(64'h1 << 63, 0, 0, 1, 64'h7ff, "R3 line 63");
    step(64'h1 << 63, 0, 1, 0, 64'h7ff, "R7 ack line 63");
    repeat (3) @(negedge clk);
    done = 1;
    report();
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
    end
  end
endmodule